// File: doc/BRIEF.md
# Three-Key Code Lock Controller

This block is a synchronous state machine that listens to a two-key keypad and raises an unlock pulse when the keys B, A, B are pressed in that order. A key-valid line marks that a key is down, and two key lines say which key it is. The machine counts a press only on the rising edge of key-valid, so a key held for many cycles counts once.

A correct sequence moves the machine along a chain of "correct so far" states. Any wrong key moves it onto a separate "wrong" chain. That chain still advances on each later press, so the user cannot tell which key was wrong until all three keys are in. A 4-bit count of keys entered is decoded from the state and is meant to drive a digit display. The unlock pulse is also decoded from the state. After the third key, the machine returns to its idle state on the next clock, whatever the sequence was. Inputs are assumed to be already synchronous to the clock.

Top module: `code_lock`

## Requirements
- R1: While `rst` is high on a clock edge, the machine goes to idle: after that edge `key_count` is 0 and `unlock` is 0.
- R2: A press is registered when `key_valid` is 1 in a cycle and was 0 in the previous cycle. In that cycle, `key_a`=1 with `key_b`=0 is key A, and `key_a`=0 with `key_b`=1 is key B.
- R3: In a cycle with no registered press, a state with a count below 3 keeps its value.
- R4: A key held for several cycles counts as one press. It takes a release (`key_valid`=0) before the next press.
- R5: The presses B, A, B from idle give `key_count` values 1, 2 and 3 in turn. `unlock` is 1 in the cycle where the count is 3.
- R6: A wrong key at the first, second or third position still moves the count through 1, 2 and 3 on each press. `unlock` stays 0 throughout.
- R7: A press with `key_a` and `key_b` both 1, or both 0, is treated as a wrong key.
- R8: `key_count` is always 0, 1, 2 or 3. It reads 0 in idle and n after n keys of the current attempt.
- R9: One cycle after `key_count` reads 3, the machine is idle again (count 0). A new attempt can then start.
- R10: `unlock` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | A key is down |
| key_a | input | 1 | Key line A |
| key_b | input | 1 | Key line B |
| unlock | output | 1 | One-cycle pulse after a correct code |
| key_count | output | 4 | Keys entered in the current attempt |

## Verification
The correct code is entered with idle gaps between the keys. It is also entered directly after an earlier attempt, to show that each attempt starts fresh from idle. A wrong key is placed at each of the three positions in turn. The count must then look the same as on the correct path while the unlock pulse stays low, which tells the wrong chain apart from the correct chain. Held keys, invalid key codes and a reset in the middle of an attempt show that only rising edges of key-valid advance the machine, that invalid codes are treated as wrong keys, and that reset clears any partial progress.

// File: rtl/code_lock.sv
module code_lock #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_valid,
  input  logic             key_a,
  input  logic             key_b,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);

  typedef enum logic [2:0] {
    S_IDLE, S_OK1, S_OK2, S_OK3, S_BAD1, S_BAD2, S_BAD3
  } lock_st_e;

  lock_st_e st, st_nx;
  logic     kv_q;

  wire press  = key_valid & ~kv_q;
  wire is_a   = key_a & ~key_b;
  wire is_b   = key_b & ~key_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      kv_q <= 1'b0;
    end else begin
      st   <= st_nx;
      kv_q <= key_valid;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (press) st_nx = is_b ? S_OK1 : S_BAD1;
      S_OK1:  if (press) st_nx = is_a ? S_OK2 : S_BAD2;
      S_OK2:  if (press) st_nx = is_b ? S_OK3 : S_BAD3;
      S_BAD1: if (press) st_nx = S_BAD2;
      S_BAD2: if (press) st_nx = S_BAD3;
      S_OK3, S_BAD3: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign unlock = (st == S_OK3);

  always_comb begin
    case (st)
      S_OK1, S_BAD1: key_count = CNT_W'(1);
      S_OK2, S_BAD2: key_count = CNT_W'(2);
      S_OK3, S_BAD3: key_count = CNT_W'(3);
      default:       key_count = '0;
    endcase
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (key_count == 0 && !unlock));

  assert_hold_no_key_R3: assert property (@(posedge clk) disable iff (rst)
    (!key_valid && key_count != 3) |=> $stable(key_count));

  assert_held_once_R4: assert property (@(posedge clk) disable iff (rst)
    (key_valid && kv_q && key_count != 3) |=> $stable(key_count));

  assert_unlock_at_three_R5: assert property (@(posedge clk) disable iff (rst)
    unlock |-> key_count == 3);

  assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
    key_count <= 3);

  assert_return_idle_R9: assert property (@(posedge clk) disable iff (rst)
    key_count == 3 |=> key_count == 0);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock);

endmodule

// File: tb/test_code_lock.sv
`timescale 1ns/1ps
module test_code_lock;
  logic clk = 0, rst = 1, kv = 0, ka = 0, kb = 0;
  logic unlock;
  logic [3:0] key_count;
  int compared = 0, mismatched = 0;
  int m_st = 0;
  bit m_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  code_lock i_code_lock (.clk(clk), .rst(rst), .key_valid(kv), .key_a(ka),
                         .key_b(kb), .unlock(unlock), .key_count(key_count));

  function automatic int exp_cnt(int s);
    return s == 0 ? 0 : (s <= 3 ? s : s - 3);
  endfunction

  always @(posedge clk) begin
    bit pr, a_ok, b_ok;
    if (rst) begin
      m_st = 0; m_prev = 0;
    end else begin
      pr = kv && !m_prev;
      m_prev = kv;
      a_ok = ka && !kb;
      b_ok = kb && !ka;
      if (m_st == 3 || m_st == 6) m_st = 0;
      else if (pr) begin
        case (m_st)
          0: m_st = b_ok ? 1 : 4;
          1: m_st = a_ok ? 2 : 5;
          2: m_st = b_ok ? 3 : 6;
          4: m_st = 5;
          5: m_st = 6;
          default: m_st = 0;
        endcase
      end
    end
  end

  task automatic check(string tag);
    compared++;
    if (key_count !== 4'(exp_cnt(m_st))) begin
      mismatched++;
      $display("FAIL %s key_count actual=%0d expected=%0d", tag, key_count, exp_cnt(m_st));
    end
    compared++;
    if (unlock !== (m_st == 3)) begin
      mismatched++;
      $display("FAIL %s unlock actual=%0b expected=%0b", tag, unlock, m_st == 3);
    end
  endtask

  task automatic step(bit k, bit a, bit b, string tag);
    kv = k; ka = a; kb = b;
    @(negedge clk);
    check(tag);
  endtask

  task automatic press(bit a, bit b, string tag);
    step(1, a, b, tag);
    step(0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 5000);
    mismatched++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1_R8");
    // R5 correct code with idle gaps (R3)
    press(0, 1, "R5"); step(0, 0, 0, "R3"); step(0, 0, 0, "R3");
    press(1, 0, "R5"); step(0, 0, 0, "R3");
    press(0, 1, "R5_R10_R9");
    step(0, 0, 0, "R9");
    // R5 back-to-back attempt
    press(0, 1, "R5"); press(1, 0, "R5"); press(0, 1, "R5_R9");
    // R6 wrong key at each position
    press(1, 0, "R6"); press(1, 0, "R6"); press(0, 1, "R6"); step(0, 0, 0, "R9");
    press(0, 1, "R6"); press(0, 1, "R6"); press(0, 1, "R6"); step(0, 0, 0, "R9");
    press(0, 1, "R6"); press(1, 0, "R6"); press(1, 0, "R6"); step(0, 0, 0, "R9");
    // R7 invalid codes
    press(1, 1, "R7"); press(1, 0, "R7"); press(0, 1, "R7"); step(0, 0, 0, "R7");
    press(0, 1, "R7"); press(0, 0, "R7"); press(0, 1, "R7"); step(0, 0, 0, "R7");
    press(0, 1, "R7"); press(1, 0, "R7"); press(1, 1, "R7"); step(0, 0, 0, "R7");
    // R4 held keys
    for (int i = 0; i < 5; i++) step(1, 0, 1, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R4");
    step(1, 0, 1, "R4");
    step(0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 0, 1, "R4_R9");
    step(0, 0, 0, "R4");
    // R2 key lines change while held: no extra press
    step(1, 0, 1, "R2"); step(1, 1, 0, "R2"); step(1, 0, 1, "R2"); step(0, 0, 0, "R2");
    press(1, 0, "R2"); press(0, 1, "R2"); step(0, 0, 0, "R2");
    // R1 reset mid-attempt
    press(0, 1, "R1"); press(1, 0, "R1");
    rst = 1; step(0, 0, 0, "R1"); rst = 0;
    step(0, 0, 0, "R1");
    press(0, 1, "R1_R5"); press(1, 0, "R1_R5"); press(0, 1, "R1_R5");
    step(0, 0, 0, "R8");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule